// File: doc/BRIEF.md
# Compressed Automaton Transition Stepper

This block moves a multi-pattern string-matching automaton forward by one input byte. The automaton is held in two memories that the block reads through its own ports. The state memory holds one record per state. The list memory holds, for every state, a packed list of successor state indices. A state record does not hold a pointer for each of the 256 possible byte values. It holds a 256-bit presence map with one bit per byte value. The block finds the successor by counting the set map bits that lie below the input byte and adding that count to the state's list base.

A caller issues `start` with the current state, the byte and its stream position. The block then reads the state record and tests the map bit for the byte. If the bit is clear, the block follows the record's failure link and tests the same byte again, until a transition is found or the failure chain reaches the root. When it ends at the root, the block raises a flag so that a separate root lookup can supply the state. When a transition is found, the block also reads the entered state's record. If that record carries a non-zero match pointer, the block reports a match together with the byte position.

Top module: `bmac_stepper`

## Requirements
- R1: After reset, `busy`, `done` and `match_valid` are low, and neither memory read enable is asserted while the block is idle.
- R2: The state word is packed from the least significant bit upward as: presence map in bits [255:0], list base in the next LIST_W bits, failure index in the next STATE_W bits, match pointer in the next MATCH_W bits, information byte in the top 8 bits. Bit c of the map stands for byte value c. When that bit is set, `next_state` is the list memory entry at address base plus the number of set map bits in positions 0 to c-1, taken modulo 2^LIST_W.
- R3: A step without any failure hop raises `done` in the 8th cycle, counting the clock edge that samples `start` as the first. Each failure hop adds 2 cycles. A step that ends at the root raises `done` after 3 + 2*hops edges.
- R4: When the map bit is clear in a state whose failure index is non-zero, the block moves to the failure state and tests the same byte there. It repeats this for as many hops as the chain requires.
- R5: When the map bit is clear and the failure index is 0, `done` rises with `root_fail`=1 and `next_state`=0. The root record is not tested.
- R6: At state 0 (the root), a clear map bit ends the step with `next_state`=0 and `root_fail`=1, and no failure is followed.
- R7: When a transition is taken and the entered state's match pointer is non-zero, `match_valid` is high in the `done` cycle. In that cycle `match_ptr` carries the pointer and `match_pos` carries the position given at `start`. A zero pointer, or a step that ends at the root, gives no `match_valid`.
- R8: `done` lasts exactly one cycle. `busy` is high from the cycle after `start` until the cycle before `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The running step keeps its inputs, and no second result follows.
- R10: `next_info` carries the information byte of the entered state, or 0 when `root_fail` is set.
- R11: Byte value 0 uses an offset of 0. Byte value 255 counts all 255 lower map bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a step; sampled only when idle |
| in_state | input | STATE_W | Current automaton state |
| in_sym | input | 8 | Input byte |
| in_pos | input | POS_W | Stream position of the byte |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle result strobe |
| next_state | output | STATE_W | Resulting state |
| root_fail | output | 1 | Root reached with no transition; root lookup must supply the state |
| next_info | output | 8 | Information byte of the entered state |
| match_valid | output | 1 | Entered state carries a match |
| match_ptr | output | MATCH_W | Match pointer of the entered state |
| match_pos | output | POS_W | Byte position of the match |
| state_rd_en | output | 1 | State memory read enable |
| state_rd_addr | output | STATE_W | State memory read address |
| state_rd_data | input | REC_W | State record, valid one cycle after the read |
| list_rd_en | output | 1 | List memory read enable |
| list_rd_addr | output | LIST_W | List memory read address |
| list_rd_data | input | STATE_W | List entry, valid one cycle after the read |

## Verification
Bytes are chosen so that the count of lower map bits is 0, 1, 2, 128 and 255. This separates a correct prefix count from an off-by-one error or from one that counts the tested bit itself. A fully populated map against a sparse one separates the four partial-count lanes from one another. Failure chains of zero, one and two hops that end in a transition, together with chains that end at the root, separate a correct walk from one that stops early or tests the root. Their latencies expose any extra or missing cycle. Entered states with and without a match pointer confirm the match pulse and its position.

// File: rtl/bmac_pkg.sv
`timescale 1ns/1ps
package bmac_pkg;

    // Step sequencer; ST_RREQ/ST_TEST repeat once per failure hop.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RREQ,
        ST_TEST,
        ST_POP,
        ST_ADD,
        ST_LREQ,
        ST_LDAT,
        ST_MCHK
    } step_e;

endpackage

// File: rtl/bmac_lane_count.sv
`timescale 1ns/1ps
module bmac_lane_count #(
    parameter int LANE_W = 64,
    parameter int CNT_W  = $clog2(LANE_W + 1)
) (
    input  logic [LANE_W-1:0] bits,
    output logic [CNT_W-1:0]  ones
);

    always_comb begin
        ones = '0;
        for (int i = 0; i < LANE_W; i++) begin
            ones = ones + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/bmac_offset_sum.sv
`timescale 1ns/1ps
module bmac_offset_sum #(
    parameter int N_LANES = 4,
    parameter int LCNT_W  = 7,
    parameter int OFS_W   = 9
) (
    input  logic [N_LANES-1:0][LCNT_W-1:0] parts,
    output logic [OFS_W-1:0]               total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < N_LANES; i++) begin
            total = total + OFS_W'(parts[i]);
        end
    end

endmodule

// File: rtl/bmac_stepper.sv
`timescale 1ns/1ps
module bmac_stepper #(
    parameter int STATE_W = 4,
    parameter int LIST_W  = 8,
    parameter int MATCH_W = 6,
    parameter int POS_W   = 16,
    parameter int INFO_W  = 8,
    parameter int SYM_W   = 8,
    parameter int LANE_W  = 64,
    localparam int BMAP_W = 1 << SYM_W,
    localparam int REC_W  = BMAP_W + LIST_W + STATE_W + MATCH_W + INFO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] in_state,
    input  logic [SYM_W-1:0]   in_sym,
    input  logic [POS_W-1:0]   in_pos,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] next_state,
    output logic               root_fail,
    output logic [INFO_W-1:0]  next_info,
    output logic               match_valid,
    output logic [MATCH_W-1:0] match_ptr,
    output logic [POS_W-1:0]   match_pos,
    output logic               state_rd_en,
    output logic [STATE_W-1:0] state_rd_addr,
    input  logic [REC_W-1:0]   state_rd_data,
    output logic               list_rd_en,
    output logic [LIST_W-1:0]  list_rd_addr,
    input  logic [STATE_W-1:0] list_rd_data
);

    import bmac_pkg::*;

    localparam int N_LANES = BMAP_W / LANE_W;
    localparam int LCNT_W  = $clog2(LANE_W + 1);
    localparam int OFS_W   = SYM_W + 1;
    localparam logic [BMAP_W-1:0] BM_ONE = {{(BMAP_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [INFO_W-1:0]  info;
        logic [MATCH_W-1:0] mptr;
        logic [STATE_W-1:0] fail;
        logic [LIST_W-1:0]  base;
        logic [BMAP_W-1:0]  bmap;
    } rec_t;

    typedef struct packed {
        step_e                            fsm;
        logic [STATE_W-1:0]               cur;
        logic [SYM_W-1:0]                 sym;
        logic [POS_W-1:0]                 pos;
        logic [BMAP_W-1:0]                masked;
        logic [LIST_W-1:0]                base;
        logic [N_LANES-1:0][LCNT_W-1:0]   lanes;
        logic [LIST_W-1:0]                ladr;
        logic [STATE_W-1:0]               nxt;
        logic                             done;
        logic                             rfail;
        logic [STATE_W-1:0]               out_state;
        logic [INFO_W-1:0]                out_info;
        logic                             mvalid;
        logic [MATCH_W-1:0]               mptr;
        logic [POS_W-1:0]                 mpos;
    } regs_t;

    regs_t r_d, r_q;
    rec_t  rec;
    logic [BMAP_W-1:0] below_mask;
    logic [N_LANES-1:0][LCNT_W-1:0] lane_ones;
    logic [OFS_W-1:0] ofs_total;

    assign rec        = rec_t'(state_rd_data);
    assign below_mask = (BM_ONE << r_q.sym) - BM_ONE;

    // One partial population count per lane of the masked map.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        bmac_lane_count #(
            .LANE_W (LANE_W),
            .CNT_W  (LCNT_W)
        ) u_lane (
            .bits (r_q.masked[g*LANE_W +: LANE_W]),
            .ones (lane_ones[g])
        );
    end

    bmac_offset_sum #(
        .N_LANES (N_LANES),
        .LCNT_W  (LCNT_W),
        .OFS_W   (OFS_W)
    ) u_sum (
        .parts (r_q.lanes),
        .total (ofs_total)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.mvalid = 1'b0;
        unique case (r_q.fsm)
            ST_IDLE: begin
                if (start) begin
                    r_d.cur = in_state;
                    r_d.sym = in_sym;
                    r_d.pos = in_pos;
                    r_d.fsm = ST_RREQ;
                end
            end
            ST_RREQ: r_d.fsm = ST_TEST;
            ST_TEST: begin
                if (rec.bmap[r_q.sym]) begin
                    r_d.masked = rec.bmap & below_mask;
                    r_d.base   = rec.base;
                    r_d.fsm    = ST_POP;
                end else if ((r_q.cur == '0) || (rec.fail == '0)) begin
                    r_d.done      = 1'b1;
                    r_d.rfail     = 1'b1;
                    r_d.out_state = '0;
                    r_d.out_info  = '0;
                    r_d.fsm       = ST_IDLE;
                end else begin
                    r_d.cur = rec.fail;
                    r_d.fsm = ST_RREQ;
                end
            end
            ST_POP: begin
                r_d.lanes = lane_ones;
                r_d.fsm   = ST_ADD;
            end
            ST_ADD: begin
                r_d.ladr = r_q.base + LIST_W'(ofs_total);
                r_d.fsm  = ST_LREQ;
            end
            ST_LREQ: r_d.fsm = ST_LDAT;
            ST_LDAT: begin
                r_d.nxt = list_rd_data;
                r_d.fsm = ST_MCHK;
            end
            ST_MCHK: begin
                r_d.done      = 1'b1;
                r_d.rfail     = 1'b0;
                r_d.out_state = r_q.nxt;
                r_d.out_info  = rec.info;
                if (rec.mptr != '0) begin
                    r_d.mvalid = 1'b1;
                    r_d.mptr   = rec.mptr;
                    r_d.mpos   = r_q.pos;
                end
                r_d.fsm = ST_IDLE;
            end
            default: r_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.fsm != ST_IDLE);
    assign done          = r_q.done;
    assign next_state    = r_q.out_state;
    assign root_fail     = r_q.rfail;
    assign next_info     = r_q.out_info;
    assign match_valid   = r_q.mvalid;
    assign match_ptr     = r_q.mptr;
    assign match_pos     = r_q.mpos;
    assign state_rd_en   = (r_q.fsm == ST_RREQ) || (r_q.fsm == ST_LDAT);
    assign state_rd_addr = (r_q.fsm == ST_LDAT) ? list_rd_data : r_q.cur;
    assign list_rd_en    = (r_q.fsm == ST_LREQ);
    assign list_rd_addr  = r_q.ladr;

endmodule

module bmac_stepper_chk #(
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               root_fail,
    input logic               match_valid,
    input logic [STATE_W-1:0] next_state,
    input logic               state_rd_en,
    input logic               list_rd_en
);

    // R1
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!state_rd_en && !list_rd_en));

    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_rd_en && list_rd_en));

    // R5
    root_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && root_fail) |-> (next_state == '0));

    // R7
    match_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (done && !root_fail));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind bmac_stepper bmac_stepper_chk #(.STATE_W(STATE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .root_fail   (root_fail),
    .match_valid (match_valid),
    .next_state  (next_state),
    .state_rd_en (state_rd_en),
    .list_rd_en  (list_rd_en)
);

// File: tb/bmac_stepper_tb.sv
`timescale 1ns/1ps
module bmac_stepper_tb_top;

    localparam int STATE_W = 4;
    localparam int LIST_W  = 8;
    localparam int MATCH_W = 6;
    localparam int POS_W   = 16;
    localparam int REC_W   = 256 + LIST_W + STATE_W + MATCH_W + 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [STATE_W-1:0] in_state = '0;
    logic [7:0]         in_sym = '0;
    logic [POS_W-1:0]   in_pos = '0;
    logic               busy, done, root_fail, match_valid;
    logic [STATE_W-1:0] next_state;
    logic [7:0]         next_info;
    logic [MATCH_W-1:0] match_ptr;
    logic [POS_W-1:0]   match_pos;
    logic               state_rd_en, list_rd_en;
    logic [STATE_W-1:0] state_rd_addr;
    logic [LIST_W-1:0]  list_rd_addr;
    logic [REC_W-1:0]   state_rd_data = '0;
    logic [STATE_W-1:0] list_rd_data = '0;

    logic [REC_W-1:0]   smem [16];
    logic [STATE_W-1:0] lmem [256];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bmac_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_state(in_state),
        .in_sym(in_sym), .in_pos(in_pos), .busy(busy), .done(done),
        .next_state(next_state), .root_fail(root_fail), .next_info(next_info),
        .match_valid(match_valid), .match_ptr(match_ptr), .match_pos(match_pos),
        .state_rd_en(state_rd_en), .state_rd_addr(state_rd_addr),
        .state_rd_data(state_rd_data), .list_rd_en(list_rd_en),
        .list_rd_addr(list_rd_addr), .list_rd_data(list_rd_data)
    );

    always @(posedge clk) begin
        if (state_rd_en) state_rd_data <= smem[state_rd_addr];
        if (list_rd_en)  list_rd_data  <= lmem[list_rd_addr];
    end

    typedef struct packed {
        logic [3:0]  st;
        logic [7:0]  sy;
        logic [15:0] ps;
        logic [3:0]  nx;
        logic        rf;
        logic        mv;
        logic [5:0]  mp;
        logic [7:0]  inf;
        logic [4:0]  lat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 8'h41, 16'd100, 4'd1, 1'b0, 1'b0, 6'd0,  8'h11, 5'd8},  // R2 one lower bit
        '{4'd0, 8'h42, 16'd101, 4'd2, 1'b0, 1'b1, 6'd7,  8'h12, 5'd8},  // R2 R7 two lower bits
        '{4'd0, 8'h00, 16'd102, 4'd5, 1'b0, 1'b0, 6'd0,  8'h15, 5'd8},  // R11 byte 0
        '{4'd0, 8'h50, 16'd103, 4'd0, 1'b1, 1'b0, 6'd0,  8'h00, 5'd3},  // R6 root, clear bit
        '{4'd1, 8'h42, 16'd104, 4'd3, 1'b0, 1'b1, 6'd9,  8'h13, 5'd8},  // R7
        '{4'd1, 8'h41, 16'd105, 4'd0, 1'b1, 1'b0, 6'd0,  8'h00, 5'd3},  // R5 failure is root
        '{4'd3, 8'h43, 16'd106, 4'd4, 1'b0, 1'b1, 6'd3,  8'h14, 5'd10}, // R4 one hop
        '{4'd4, 8'h43, 16'd107, 4'd4, 1'b0, 1'b1, 6'd3,  8'h14, 5'd12}, // R4 two hops
        '{4'd4, 8'h5A, 16'd108, 4'd0, 1'b1, 1'b0, 6'd0,  8'h00, 5'd7},  // R5 chain ends at root
        '{4'd2, 8'hFF, 16'd109, 4'd6, 1'b0, 1'b1, 6'd63, 8'h16, 5'd8},  // R11 byte 255 sparse
        '{4'd5, 8'hFF, 16'd110, 4'd6, 1'b0, 1'b1, 6'd63, 8'h16, 5'd8},  // R11 byte 255 full map
        '{4'd5, 8'h80, 16'd111, 4'd3, 1'b0, 1'b1, 6'd9,  8'h13, 5'd8},  // R2 128 lower bits
        '{4'd5, 8'h00, 16'd112, 4'd5, 1'b0, 1'b0, 6'd0,  8'h15, 5'd8},  // R11 full map byte 0
        '{4'd3, 8'h41, 16'd113, 4'd1, 1'b0, 1'b0, 6'd0,  8'h11, 5'd8}   // R10 info of entered state
    };

    function automatic logic [REC_W-1:0] mk_rec(input logic [255:0] bm, input logic [LIST_W-1:0] base,
                                                input logic [STATE_W-1:0] fl, input logic [MATCH_W-1:0] mp,
                                                input logic [7:0] inf);
        return {inf, mp, fl, base, bm};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_step(input logic [3:0] st, input logic [7:0] sy, input logic [15:0] ps,
                            output int lat);
        @(negedge clk);
        start = 1'b1; in_state = st; in_sym = sy; in_pos = ps;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] bm;
        int lat;
        int extra_done;

        for (int i = 0; i < 16; i++) smem[i] = '0;
        for (int i = 0; i < 256; i++) lmem[i] = '0;
        bm = '0; bm[8'h00] = 1'b1; bm[8'h41] = 1'b1; bm[8'h42] = 1'b1;
        smem[0] = mk_rec(bm, 8'd0, 4'd0, 6'd0, 8'h10);
        bm = '0; bm[8'h42] = 1'b1;
        smem[1] = mk_rec(bm, 8'd3, 4'd0, 6'd0, 8'h11);
        bm = '0; bm[8'h43] = 1'b1; bm[8'hFF] = 1'b1;
        smem[2] = mk_rec(bm, 8'd4, 4'd0, 6'd7, 8'h12);
        bm = '0; bm[8'h41] = 1'b1;
        smem[3] = mk_rec(bm, 8'd6, 4'd2, 6'd9, 8'h13);
        smem[4] = mk_rec('0, 8'd0, 4'd3, 6'd3, 8'h14);
        smem[5] = mk_rec({256{1'b1}}, 8'd0, 4'd0, 6'd0, 8'h15);
        smem[6] = mk_rec('0, 8'd0, 4'd0, 6'd63, 8'h16);
        lmem[0] = 4'd5; lmem[1] = 4'd1; lmem[2] = 4'd2; lmem[3] = 4'd3;
        lmem[4] = 4'd4; lmem[5] = 4'd6; lmem[6] = 4'd1;
        lmem[128] = 4'd3; lmem[255] = 4'd6;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "match_valid", int'(match_valid), 0);
        chk("R1", "read enables", int'({state_rd_en, list_rd_en}), 0);

        for (int v = 0; v < NV; v++) begin
            run_step(VECS[v].st, VECS[v].sy, VECS[v].ps, lat);
            chk("R3", $sformatf("latency vec %0d", v), lat, int'(VECS[v].lat));
            chk("R2", $sformatf("next_state vec %0d", v), int'(next_state), int'(VECS[v].nx));
            chk("R5", $sformatf("root_fail vec %0d", v), int'(root_fail), int'(VECS[v].rf));
            chk("R7", $sformatf("match_valid vec %0d", v), int'(match_valid), int'(VECS[v].mv));
            chk("R10", $sformatf("next_info vec %0d", v), int'(next_info), int'(VECS[v].inf));
            if (VECS[v].mv) begin
                chk("R7", $sformatf("match_ptr vec %0d", v), int'(match_ptr), int'(VECS[v].mp));
                chk("R7", $sformatf("match_pos vec %0d", v), int'(match_pos), int'(VECS[v].ps));
            end
            @(negedge clk);
            // R8 one-cycle strobe, block idle afterwards
            chk("R8", $sformatf("done pulse vec %0d", v), int'(done), 0);
            chk("R8", $sformatf("busy after vec %0d", v), int'(busy), 0);
        end

        // R9: a second start while busy must not change the running step
        @(negedge clk);
        start = 1'b1; in_state = 4'd0; in_sym = 8'h41; in_pos = 16'd500;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; in_state = 4'd2; in_sym = 8'hFF; in_pos = 16'd600;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", "latency with extra start", lat, 8);
        chk("R9", "next_state with extra start", int'(next_state), 1);
        chk("R9", "match_valid with extra start", int'(match_valid), 0);
        extra_done = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (done) extra_done++;
        end
        chk("R9", "no second result", extra_done, 0);
        chk("R9", "idle after ignored start", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule